// File: doc/BRIEF.md
# Dual-Channel Converter Status and Result Capture

This block holds the status byte shared by two converter channels, a 24-bit primary channel and a 16-bit auxiliary channel, and captures their conversion and calibration results into holding registers. The converter, its filter and the calibration arithmetic sit outside; they present done strobes, raw words, range indications and a reference-valid signal. Software reads the status byte at register address D8H. It can clear a channel's ready flag with a byte write or a bit write. It starts new cycles through a mode-register write strobe, which carries a mask of the channels being started.

Each channel has a ready flag that works as a one-deep interlock. Once a result or a coefficient has been captured, further completions on that channel are discarded until software clears the flag. Conversion words outside the range are clamped to all zeros or all ones, and the clamp is flagged. A missing external reference forces conversion words to all ones.

Top module: `dual_conv_status`

## Requirements
- R1: After a synchronous reset the status byte reads 00H, and every data and coefficient register reads zero.
- R2: The status bit positions are: 7 primary ready, 6 auxiliary ready, 5 calibration done, 4 no-reference, 3 primary error, 2 auxiliary error. Bits 1 and 0 always read 0. Software writes have no effect on bits 5 to 0.
- R3: A conversion done strobe on a channel whose ready flag is clear stores the word in that channel's data register and sets its ready flag on the next clock edge.
- R4: While a channel's ready flag is set, its conversion and calibration strobes are dropped, and its data, offset and gain registers keep their values.
- R5: A byte write to D8H with bit 7 (or bit 6) at 0 clears the primary (or auxiliary) ready flag. A bit write with value 0 to bit address DFH (or DEH) does the same. Writing 1 never sets a flag.
- R6: A mode write clears the ready and error flags of exactly the channels set in its start mask (bit 0 primary, bit 1 auxiliary). It clears the calibration flag whenever the mask is non-zero.
- R7: When a hardware set and a clear of the same flag fall in one cycle, the set wins.
- R8: A conversion with over-range stores all ones, and one with only under-range stores all zeros. Either case sets that channel's error flag. Over-range wins when both are asserted.
- R9: The no-reference flag takes the inverse of the reference-valid input, registered one cycle, while any channel is active. It reads 0 when no channel is active.
- R10: While the no-reference flag is set and the external reference is selected, conversions store all ones and set the error flag. With the internal reference selected, the raw word is stored.
- R11: An accepted calibration without a fault writes the raw word into the gain coefficient (select 1) or the offset coefficient (select 0). It also sets the channel's ready flag and the calibration flag.
- R12: An accepted calibration with a fault leaves both coefficients unchanged. It sets the channel's error flag, ready flag and calibration flag.
- R13: When calibration and conversion strobes arrive together on a channel, the calibration is taken and the conversion is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Byte write address |
| reg_wdata | input | 8 | Byte write data |
| bit_wr | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit address (D8H + bit index for the status byte) |
| bit_val | input | 1 | Bit write value |
| mode_wr | input | 1 | Mode-register write strobe |
| mode_start | input | 2 | Channels started by the mode write (bit 0 primary) |
| conv_done | input | 2 | Conversion complete strobes |
| cal_done | input | 2 | Calibration complete strobes |
| cal_gain | input | 2 | Calibration kind: 1 gain, 0 offset |
| cal_fault | input | 2 | Calibration fault, coefficient not to be written |
| over_rng | input | 2 | Conversion above range |
| under_rng | input | 2 | Conversion below range |
| ch_active | input | 2 | Channel active |
| ref_ok | input | 1 | External reference present and valid |
| ext_ref | input | 1 | External reference selected |
| pri_raw | input | PRI_W | Primary raw word (result or coefficient) |
| aux_raw | input | AUX_W | Auxiliary raw word |
| status | output | 8 | Status byte |
| pri_data | output | PRI_W | Primary result |
| aux_data | output | AUX_W | Auxiliary result |
| pri_offset | output | PRI_W | Primary offset coefficient |
| pri_gain | output | PRI_W | Primary gain coefficient |
| aux_offset | output | AUX_W | Auxiliary offset coefficient |
| aux_gain | output | AUX_W | Auxiliary gain coefficient |

## Verification
Two pairs of functions can meet in one cycle. The first is a completion that sets a ready flag together with a clear of that flag, from a status write or a mode start. The second is a calibration strobe together with a conversion strobe. The bench drives each pair on the same falling edge and judges the result after the next rising edge against its behavioural model. The set must survive the clear, and the data register must keep its old value when the calibration wins.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    localparam int          NCH       = 2;
    localparam logic [7:0]  STAT_ADDR = 8'hD8;
    localparam int          POS_CAL   = 5;
    localparam int          POS_NOREF = 4;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_CONV = 2'd1,
        CAP_CAL  = 2'd2
    } cap_kind_e;

    typedef struct packed {
        logic rdy;
        logic err;
        logic cal_evt;
    } ch_flags_t;

    function automatic int rdy_pos(input int ch);
        return 7 - ch;
    endfunction

    function automatic int err_pos(input int ch);
        return 3 - ch;
    endfunction
endpackage

// File: rtl/dcs_wr_decode.sv
module dcs_wr_decode
    import dcs_pkg::*;
(
    input  logic           reg_wr,
    input  logic [7:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    input  logic           bit_wr,
    input  logic [7:0]     bit_addr,
    input  logic           bit_val,
    output logic [NCH-1:0] sw_clr
);
    logic byte_hit;
    logic bit_hit;
    logic unused_wdata;

    assign byte_hit     = reg_wr && (reg_addr == STAT_ADDR);
    assign bit_hit      = bit_wr && (bit_addr[7:3] == STAT_ADDR[7:3]) && !bit_val;
    assign unused_wdata = ^reg_wdata[5:0];

    for (genvar c = 0; c < NCH; c++) begin : g_clr
        localparam int P = rdy_pos(c);
        assign sw_clr[c] = (byte_hit && !reg_wdata[P]) ||
                           (bit_hit && (bit_addr[2:0] == 3'(P)));
    end
endmodule

// File: rtl/dcs_ref_monitor.sv
module dcs_ref_monitor
    import dcs_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] ch_active,
    input  logic           ref_ok,
    output logic           noref
);
    always_ff @(posedge clk) begin
        if (rst)              noref <= 1'b0;
        else if (|ch_active)  noref <= !ref_ok;
        else                  noref <= 1'b0;
    end
endmodule

// File: rtl/dcs_channel.sv
module dcs_channel
    import dcs_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         sw_clr,
    input  logic         conv_done,
    input  logic         cal_done,
    input  logic         cal_gain,
    input  logic         cal_fault,
    input  logic         over_rng,
    input  logic         under_rng,
    input  logic         force_ones,
    input  logic [W-1:0] raw,
    output ch_flags_t    flags,
    output logic [W-1:0] data,
    output logic [W-1:0] offset,
    output logic [W-1:0] gain
);
    cap_kind_e    kind;
    logic [W-1:0] word;
    logic         clipped;
    logic         err_set;
    logic         rdy_q;
    logic         err_q;

    always_comb begin
        if (rdy_q)          kind = CAP_NONE;
        else if (cal_done)  kind = CAP_CAL;
        else if (conv_done) kind = CAP_CONV;
        else                kind = CAP_NONE;
    end

    always_comb begin
        word    = raw;
        clipped = 1'b0;
        if (force_ones || over_rng) begin
            word    = '1;
            clipped = 1'b1;
        end else if (under_rng) begin
            word    = '0;
            clipped = 1'b1;
        end
    end

    assign err_set = ((kind == CAP_CONV) && clipped) ||
                     ((kind == CAP_CAL) && cal_fault);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
            data   <= '0;
            offset <= '0;
            gain   <= '0;
        end else begin
            if (kind != CAP_NONE)        rdy_q <= 1'b1;
            else if (start || sw_clr)    rdy_q <= 1'b0;

            if (err_set)                 err_q <= 1'b1;
            else if (start)              err_q <= 1'b0;

            if (kind == CAP_CONV) data <= word;
            if ((kind == CAP_CAL) && !cal_fault) begin
                if (cal_gain) gain   <= raw;
                else          offset <= raw;
            end
        end
    end

    assign flags.rdy     = rdy_q;
    assign flags.err     = err_q;
    assign flags.cal_evt = (kind == CAP_CAL);
endmodule

// File: rtl/dual_conv_status.sv
module dual_conv_status
    import dcs_pkg::*;
#(
    parameter int PRI_W = 24,
    parameter int AUX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             bit_wr,
    input  logic [7:0]       bit_addr,
    input  logic             bit_val,
    input  logic             mode_wr,
    input  logic [1:0]       mode_start,
    input  logic [1:0]       conv_done,
    input  logic [1:0]       cal_done,
    input  logic [1:0]       cal_gain,
    input  logic [1:0]       cal_fault,
    input  logic [1:0]       over_rng,
    input  logic [1:0]       under_rng,
    input  logic [1:0]       ch_active,
    input  logic             ref_ok,
    input  logic             ext_ref,
    input  logic [PRI_W-1:0] pri_raw,
    input  logic [AUX_W-1:0] aux_raw,
    output logic [7:0]       status,
    output logic [PRI_W-1:0] pri_data,
    output logic [AUX_W-1:0] aux_data,
    output logic [PRI_W-1:0] pri_offset,
    output logic [PRI_W-1:0] pri_gain,
    output logic [AUX_W-1:0] aux_offset,
    output logic [AUX_W-1:0] aux_gain
);
    logic [NCH-1:0] sw_clr;
    logic [NCH-1:0] start;
    ch_flags_t      flags [NCH];
    logic           noref_q;
    logic           force_ones;
    logic           cal_q;
    logic           any_cal;

    assign start      = mode_start & {NCH{mode_wr}};
    assign force_ones = noref_q && ext_ref;

    dcs_wr_decode u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .bit_wr    (bit_wr),
        .bit_addr  (bit_addr),
        .bit_val   (bit_val),
        .sw_clr    (sw_clr)
    );

    dcs_ref_monitor u_ref (
        .clk       (clk),
        .rst       (rst),
        .ch_active (ch_active),
        .ref_ok    (ref_ok),
        .noref     (noref_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c == 0) begin : g_pri
            dcs_channel #(.W(PRI_W)) u_ch (
                .clk (clk), .rst (rst), .start (start[c]), .sw_clr (sw_clr[c]),
                .conv_done (conv_done[c]), .cal_done (cal_done[c]),
                .cal_gain (cal_gain[c]), .cal_fault (cal_fault[c]),
                .over_rng (over_rng[c]), .under_rng (under_rng[c]),
                .force_ones (force_ones), .raw (pri_raw), .flags (flags[c]),
                .data (pri_data), .offset (pri_offset), .gain (pri_gain)
            );
        end else begin : g_aux
            dcs_channel #(.W(AUX_W)) u_ch (
                .clk (clk), .rst (rst), .start (start[c]), .sw_clr (sw_clr[c]),
                .conv_done (conv_done[c]), .cal_done (cal_done[c]),
                .cal_gain (cal_gain[c]), .cal_fault (cal_fault[c]),
                .over_rng (over_rng[c]), .under_rng (under_rng[c]),
                .force_ones (force_ones), .raw (aux_raw), .flags (flags[c]),
                .data (aux_data), .offset (aux_offset), .gain (aux_gain)
            );
        end
    end

    always_comb begin
        any_cal = 1'b0;
        for (int c = 0; c < NCH; c++) any_cal = any_cal | flags[c].cal_evt;
    end

    always_ff @(posedge clk) begin
        if (rst)                          cal_q <= 1'b0;
        else if (any_cal)                 cal_q <= 1'b1;
        else if (mode_wr && |mode_start)  cal_q <= 1'b0;
    end

    always_comb begin
        status            = 8'h00;
        status[POS_CAL]   = cal_q;
        status[POS_NOREF] = noref_q;
        for (int c = 0; c < NCH; c++) begin
            status[rdy_pos(c)] = flags[c].rdy;
            status[err_pos(c)] = flags[c].err;
        end
    end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
    parameter int PRI_W = 24,
    parameter int AUX_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_wr,
    input logic [1:0]       mode_start,
    input logic [1:0]       conv_done,
    input logic [1:0]       cal_done,
    input logic [1:0]       cal_fault,
    input logic [1:0]       over_rng,
    input logic [1:0]       ch_active,
    input logic             ref_ok,
    input logic [7:0]       status,
    input logic [PRI_W-1:0] pri_data,
    input logic [PRI_W-1:0] pri_offset,
    input logic [PRI_W-1:0] pri_gain,
    input logic [AUX_W-1:0] aux_data,
    input logic [AUX_W-1:0] aux_offset,
    input logic [AUX_W-1:0] aux_gain
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        status[1:0] == 2'b00);

    a_r3_pri_ready_set: assert property (@(posedge clk) disable iff (rst)
        (conv_done[0] && !status[7]) |=> status[7]);

    a_r4_pri_blocked: assert property (@(posedge clk) disable iff (rst)
        status[7] |=> ($stable(pri_data) && $stable(pri_offset) && $stable(pri_gain)));

    a_r4_aux_blocked: assert property (@(posedge clk) disable iff (rst)
        status[6] |=> ($stable(aux_data) && $stable(aux_offset) && $stable(aux_gain)));

    a_r6_pri_start_clears: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_start[0] && !conv_done[0] && !cal_done[0]) |=> (!status[7] && !status[3]));

    a_r6_cal_cleared: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && (mode_start != 2'b00) && (cal_done == 2'b00)) |=> !status[5]);

    a_r8_pri_over_clamp: assert property (@(posedge clk) disable iff (rst)
        (conv_done[0] && !cal_done[0] && !status[7] && over_rng[0]) |=> ((&pri_data) && status[3]));

    a_r9_noref_follows: assert property (@(posedge clk) disable iff (rst)
        (ch_active != 2'b00) |=> (status[4] == !$past(ref_ok)));

    a_r9_noref_idle: assert property (@(posedge clk) disable iff (rst)
        (ch_active == 2'b00) |=> !status[4]);

    a_r11_cal_flag: assert property (@(posedge clk) disable iff (rst)
        (cal_done[1] && !status[6]) |=> (status[5] && status[6]));

    a_r12_fault_keeps: assert property (@(posedge clk) disable iff (rst)
        (cal_done[0] && cal_fault[0]) |=> ($stable(pri_offset) && $stable(pri_gain)));
endmodule

bind dual_conv_status dcs_checker #(.PRI_W(PRI_W), .AUX_W(AUX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (mode_wr),
    .mode_start (mode_start),
    .conv_done  (conv_done),
    .cal_done   (cal_done),
    .cal_fault  (cal_fault),
    .over_rng   (over_rng),
    .ch_active  (ch_active),
    .ref_ok     (ref_ok),
    .status     (status),
    .pri_data   (pri_data),
    .pri_offset (pri_offset),
    .pri_gain   (pri_gain),
    .aux_data   (aux_data),
    .aux_offset (aux_offset),
    .aux_gain   (aux_gain)
);

// File: tb/dual_conv_status_tb.sv
module dual_conv_status_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRI_W      = 24;
    localparam int AUX_W      = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             reg_wr, bit_wr, bit_val, mode_wr, ref_ok, ext_ref;
    logic [7:0]       reg_addr, reg_wdata, bit_addr;
    logic [1:0]       mode_start, conv_done, cal_done, cal_gain, cal_fault;
    logic [1:0]       over_rng, under_rng, ch_active;
    logic [PRI_W-1:0] pri_raw, pri_data, pri_offset, pri_gain;
    logic [AUX_W-1:0] aux_raw, aux_data, aux_offset, aux_gain;
    logic [7:0]       status;

    dual_conv_status #(.PRI_W(PRI_W), .AUX_W(AUX_W)) dut_i (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .bit_wr (bit_wr), .bit_addr (bit_addr),
        .bit_val (bit_val), .mode_wr (mode_wr), .mode_start (mode_start),
        .conv_done (conv_done), .cal_done (cal_done), .cal_gain (cal_gain),
        .cal_fault (cal_fault), .over_rng (over_rng), .under_rng (under_rng),
        .ch_active (ch_active), .ref_ok (ref_ok), .ext_ref (ext_ref),
        .pri_raw (pri_raw), .aux_raw (aux_raw), .status (status),
        .pri_data (pri_data), .aux_data (aux_data), .pri_offset (pri_offset),
        .pri_gain (pri_gain), .aux_offset (aux_offset), .aux_gain (aux_gain)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural reference state
    bit          m_rdy [2];
    bit          m_err [2];
    bit          m_cal, m_noref;
    logic [31:0] m_data [2];
    logic [31:0] m_off  [2];
    logic [31:0] m_gain [2];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_rdy[0], m_rdy[1], m_cal, m_noref, m_err[0], m_err[1], 2'b00};
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_rdy[c] = 0; m_err[c] = 0;
            m_data[c] = 0; m_off[c] = 0; m_gain[c] = 0;
        end
        m_cal = 0; m_noref = 0;
    endtask

    task automatic model_step();
        bit          cal_set = 0;
        bit          start_any;
        start_any = mode_wr && (mode_start != 2'b00);
        for (int c = 0; c < 2; c++) begin
            logic [31:0] raw  = (c == 0) ? 32'(pri_raw) : 32'(aux_raw);
            logic [31:0] ones = (c == 0) ? 32'h00FF_FFFF : 32'h0000_FFFF;
            bit sw = (reg_wr && reg_addr == 8'hD8 && !reg_wdata[7-c]) ||
                     (bit_wr && bit_addr == 8'(8'hD8 + 7 - c) && !bit_val);
            bit st = mode_wr && mode_start[c];
            bit take_cal  = cal_done[c] && !m_rdy[c];
            bit take_conv = conv_done[c] && !m_rdy[c] && !cal_done[c];
            bit seterr = 0;
            if (take_cal) begin
                cal_set = 1;
                if (cal_fault[c])     seterr = 1;
                else if (cal_gain[c]) m_gain[c] = raw;
                else                  m_off[c] = raw;
            end
            if (take_conv) begin
                if ((m_noref && ext_ref) || over_rng[c]) begin m_data[c] = ones; seterr = 1; end
                else if (under_rng[c]) begin m_data[c] = 0; seterr = 1; end
                else m_data[c] = raw;
            end
            if (take_cal || take_conv) m_rdy[c] = 1;
            else if (sw || st)         m_rdy[c] = 0;
            if (seterr)   m_err[c] = 1;
            else if (st)  m_err[c] = 0;
        end
        if (cal_set)        m_cal = 1;
        else if (start_any) m_cal = 0;
        m_noref = (ch_active != 2'b00) ? !ref_ok : 1'b0;
    endtask

    task automatic compare_all(input string req);
        chk(req, "status",     32'(status),     32'(exp_status()));
        chk(req, "pri_data",   32'(pri_data),   m_data[0]);
        chk(req, "aux_data",   32'(aux_data),   m_data[1]);
        chk(req, "pri_offset", 32'(pri_offset), m_off[0]);
        chk(req, "pri_gain",   32'(pri_gain),   m_gain[0]);
        chk(req, "aux_offset", 32'(aux_offset), m_off[1]);
        chk(req, "aux_gain",   32'(aux_gain),   m_gain[1]);
    endtask

    task automatic tick(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(req);
        reg_wr = 0; bit_wr = 0; mode_wr = 0;
        conv_done = 0; cal_done = 0; mode_start = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1; reg_wr = 0; bit_wr = 0; bit_val = 0; mode_wr = 0;
        reg_addr = 0; reg_wdata = 0; bit_addr = 0; mode_start = 0;
        conv_done = 0; cal_done = 0; cal_gain = 0; cal_fault = 0;
        over_rng = 0; under_rng = 0; ch_active = 0; ref_ok = 1; ext_ref = 0;
        pri_raw = 0; aux_raw = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        compare_all("R1");
        chk("R1", "status literal", 32'(status), 32'h00);

        // R3: primary conversion captured
        ch_active = 2'b11; pri_raw = 24'h123456; conv_done = 2'b01; tick("R3");
        chk("R3", "pri_data literal", 32'(pri_data), 32'h123456);
        chk("R3", "status literal", 32'(status), 32'h80);

        // R4: completions dropped while ready is set
        pri_raw = 24'h654321; conv_done = 2'b01; tick("R4");
        cal_done = 2'b01; cal_gain = 2'b01; tick("R4");
        chk("R4", "pri_gain held", 32'(pri_gain), 32'h0);

        // R5 + R2: byte write clears rdy0 only; ones elsewhere ignored
        reg_wr = 1; reg_addr = 8'hD8; reg_wdata = 8'h7F; tick("R5");
        chk("R2", "status literal", 32'(status), 32'h00);

        // R8: auxiliary over-range
        aux_raw = 16'h1234; over_rng = 2'b10; conv_done = 2'b10; tick("R8");
        chk("R8", "aux_data ones", 32'(aux_data), 32'hFFFF);
        chk("R8", "status literal", 32'(status), 32'h44);
        over_rng = 0;

        // R5: bit write clears rdy1; R2: bit write to err bit ignored
        bit_wr = 1; bit_addr = 8'hDE; bit_val = 0; tick("R5");
        bit_wr = 1; bit_addr = 8'hDA; bit_val = 0; tick("R2");
        bit_wr = 1; bit_addr = 8'hDE; bit_val = 1; tick("R5");
        chk("R5", "status literal", 32'(status), 32'h04);

        // R6: start on primary leaves auxiliary error; start on auxiliary clears it
        mode_wr = 1; mode_start = 2'b01; tick("R6");
        chk("R6", "status literal", 32'(status), 32'h04);
        mode_wr = 1; mode_start = 2'b10; tick("R6");
        chk("R6", "status literal", 32'(status), 32'h00);

        // R8: over wins over under; then under alone
        pri_raw = 24'h00AA55; over_rng = 2'b01; under_rng = 2'b01; conv_done = 2'b01; tick("R8");
        over_rng = 0;
        mode_wr = 1; mode_start = 2'b01; tick("R6");
        conv_done = 2'b01; tick("R8");
        chk("R8", "pri_data zeros", 32'(pri_data), 32'h0);
        under_rng = 0;

        // R7: set beats software clear and mode start in the same cycle
        mode_wr = 1; mode_start = 2'b11; tick("R6");
        pri_raw = 24'h0F0F0F; conv_done = 2'b01; reg_wr = 1; reg_addr = 8'hD8; reg_wdata = 8'h00;
        mode_wr = 1; mode_start = 2'b01; tick("R7");
        chk("R7", "rdy0 kept", 32'(status[7]), 32'h1);

        // R9 / R10: missing reference
        mode_wr = 1; mode_start = 2'b11; tick("R6");
        ref_ok = 0; tick("R9");
        chk("R9", "noref set", 32'(status[4]), 32'h1);
        ext_ref = 0; pri_raw = 24'h345678; conv_done = 2'b01; tick("R10");
        mode_wr = 1; mode_start = 2'b01; tick("R6");
        ext_ref = 1; aux_raw = 16'h0101; conv_done = 2'b10; tick("R10");
        chk("R10", "aux forced ones", 32'(aux_data), 32'hFFFF);
        ch_active = 2'b00; tick("R9");
        chk("R9", "noref idle", 32'(status[4]), 32'h0);
        ref_ok = 1; ext_ref = 0; ch_active = 2'b11;
        mode_wr = 1; mode_start = 2'b11; tick("R6");

        // R11: calibrations write coefficients and set the calibration flag
        pri_raw = 24'hABCDEF; cal_done = 2'b01; cal_gain = 2'b01; cal_fault = 0; tick("R11");
        chk("R11", "pri_gain literal", 32'(pri_gain), 32'hABCDEF);
        aux_raw = 16'h5A5A; cal_done = 2'b10; cal_gain = 2'b00; tick("R11");
        chk("R11", "status literal", 32'(status), 32'hE0);
        mode_wr = 1; mode_start = 2'b11; tick("R6");

        // R12: faulted calibration keeps coefficients
        pri_raw = 24'h111111; cal_done = 2'b01; cal_gain = 2'b00; cal_fault = 2'b01; tick("R12");
        chk("R12", "pri_offset held", 32'(pri_offset), 32'h0);
        chk("R12", "status literal", 32'(status), 32'hA8);
        cal_fault = 0;
        mode_wr = 1; mode_start = 2'b11; tick("R6");

        // R13: calibration and conversion together
        aux_raw = 16'h7777; cal_done = 2'b10; conv_done = 2'b10; cal_gain = 2'b10; tick("R13");
        chk("R13", "aux_gain literal", 32'(aux_gain), 32'h7777);
        mode_wr = 1; mode_start = 2'b00; tick("R6");

        summary();
        $finish;
    end
endmodule